// File: doc/BRIEF.md
# UTOPIA Level 2 Slave Cell Receiver

This block sits on the physical-layer side of a UTOPIA Level 2 link and takes ATM cells that the ATM-layer master sends on the transmit-direction bus. It answers the master's flow-control question with a cell-available flag. In single-PHY mode that flag is always driven. In multi-PHY mode it is driven only when the master polls this port's configured address. The flag comes out as a value plus an output enable, and the pad ring turns the pair into a tristate line.

Each accepted word is written, one per clock, into an external buffer that holds four cells. The block polices cell length and parity. A cell that ends early is thrown away. Words past the nominal length are dropped, but the cell is still kept. A cell with a parity error can optionally be discarded. A discarded cell never advances the buffer's cell slot, so the next cell is written over it. Four one-cycle pulses report each outcome, and a release pulse from the local reader frees one cell.

Top module: `utl2_cell_rx`

## Requirements
- R1: A word is taken on a rising edge only while `tx_enb_n` is 0. `tx_soc` = 1 marks the first word of a cell. A word with `tx_soc` = 0 that arrives when no cell is open is written nowhere.
- R2: With `cfg_mphy` = 1, `clav_oe` is 1 in the cycle after `tx_addr` equals `cfg_addr`, and 0 otherwise. `clav_o` is 0 whenever `clav_oe` is 0.
- R3: The address 31 is the null address. With `cfg_mphy` = 1 and `cfg_addr` = 31, polling address 31 leaves `clav_oe` at 0.
- R4: With `cfg_mphy` = 0, `clav_oe` is 1 from the first clock after reset. `clav_o` is 1 exactly when the buffer has room for another whole cell.
- R5: A cell is 53 words on an 8-bit bus and 27 words on a 16-bit bus. Word k of a cell in slot s is written to address s*CW+k, one clock after it is taken. `stat_cell_ok` pulses for one cycle one clock after the last word, and the slot then advances modulo 4.
- R6: A start-of-cell that arrives before the open cell is complete discards that cell. `stat_bad_len` and `stat_drop` each pulse once, and the new cell is written from the same slot base.
- R7: Words after the last word of a cell and before the next start-of-cell are not written. `stat_bad_len` pulses once, and the cell is still reported by `stat_cell_ok`.
- R8: Parity is odd: the XOR of the data bits and `tx_prty` must be 1. When `cfg_par_en` = 1, each word that fails this check raises `stat_par_err` for one cycle. When `cfg_par_en` = 0, no pulse is raised.
- R9: With `cfg_par_en` = 1 and `cfg_par_drop` = 1, a cell that has any parity error is discarded with a `stat_drop` pulse instead of `stat_cell_ok`, and its slot is reused. With `cfg_par_drop` = 0, the cell is kept.
- R10: Four committed cells fill the buffer. A cell being received also counts against the space that `clav_o` reports. A one-cycle `cell_release` pulse frees one committed cell.
- R11: A start-of-cell that finds four cells committed causes that whole cell to be skipped: no word is written, `stat_drop` pulses once, and `stat_cell_ok` does not pulse.
- R12: While `rst_n` is 0, `clav_o`, `clav_oe`, `buf_we` and every stat pulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mphy | input | 1 | 1 = multi-PHY polling mode, 0 = single-PHY mode |
| cfg_addr | input | 5 | This port's polling address (31 = null) |
| cfg_par_en | input | 1 | Enable odd-parity checking |
| cfg_par_drop | input | 1 | Discard cells that have a parity error |
| tx_addr | input | 5 | Poll address from the master |
| tx_enb_n | input | 1 | Active-low data-valid from the master |
| tx_soc | input | 1 | Start-of-cell marker on the first word |
| tx_data | input | BUS_W | Cell data word |
| tx_prty | input | 1 | Odd-parity bit for `tx_data` |
| clav_o | output | 1 | Cell-available value |
| clav_oe | output | 1 | Output enable for the cell-available line |
| buf_we | output | 1 | Buffer write strobe |
| buf_waddr | output | AW | Buffer word address |
| buf_wdata | output | BUS_W | Buffer write data |
| cell_release | input | 1 | Local reader has freed one cell |
| stat_cell_ok | output | 1 | Pulse: cell committed |
| stat_bad_len | output | 1 | Pulse: short or overlong cell |
| stat_par_err | output | 1 | Pulse: parity error on a word |
| stat_drop | output | 1 | Pulse: cell discarded |

## Verification
The hardest states to reach are those where a length or parity decision lands on the same word as a buffer-space decision. Examples are a short cell cut off by a start-of-cell that must reuse the abandoned slot, and a start-of-cell that meets a full buffer. The stimulus walks a table of cell shapes (short, overlong, single-word, parity error on the first or last word, each policy switch). Expected slot bases are tracked from the committed-cell count, so a reused slot shows up as a last write address. Directed sequences then fill the buffer without releases. They check the flag while a fourth cell is still arriving, then send a fifth cell that must be skipped.

// File: rtl/utl2_rx_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, the receive state type and the cell-length helper
// for the UTOPIA Level 2 slave cell receiver.
// Assumes bus widths of 8 or 16 bits only.
package utl2_rx_pkg;

    localparam logic [4:0] NULL_ADDR = 5'd31;

    // Receive state of the capture engine
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // no cell open
        ST_BODY = 3'd1,   // cell open, words still expected
        ST_FULL = 3'd2,   // last word taken, no extra word yet
        ST_LONG = 3'd3,   // extra words being thrown away
        ST_SKIP = 3'd4    // cell refused for lack of room
    } rx_state_t;

    // Words per cell for a given bus width (54 bytes on 16 bits, 53 on 8)
    function automatic int cell_words(input int bus_w);
        return (bus_w == 16) ? 27 : 53;
    endfunction

endpackage

// File: rtl/utl2_rx_poll.sv
`timescale 1ns/1ps
// Module: poll responder. Produces the registered cell-available value and
// its output enable. In multi-PHY mode it answers only its own address and
// never the null address; in single-PHY mode it always drives.
// Assumes the pad ring builds the tristate from clav_o / clav_oe.
module utl2_rx_poll (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_mphy,
    input  logic [4:0] cfg_addr,
    input  logic [4:0] poll_addr,
    input  logic       room,
    output logic       clav_o,
    output logic       clav_oe
);
    import utl2_rx_pkg::*;

    logic hit;

    // Address match for this port, excluding the null address
    always_comb begin
        hit = (poll_addr == cfg_addr) && (cfg_addr != NULL_ADDR);
    end

    // Register the response one cycle after the poll address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clav_o  <= 1'b0;
            clav_oe <= 1'b0;
        end else if (cfg_mphy) begin
            clav_oe <= hit;
            clav_o  <= hit && room;
        end else begin
            clav_oe <= 1'b1;
            clav_o  <= room;
        end
    end

    // R2: value is never driven high while the line is released
    p_clav_needs_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clav_o |-> clav_oe);

    // R3: polling the null address in multi-PHY mode never enables the line
    p_null_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mphy && poll_addr == NULL_ADDR) |=> !clav_oe);

endmodule

// File: rtl/utl2_rx_occupancy.sv
`timescale 1ns/1ps
// Module: cell occupancy counter. Tracks committed cells in the buffer,
// adds commits and subtracts releases, and reports room for a new cell
// (admission) and room counting the cell in progress (flow control).
// Assumes commit is only raised for a cell admitted with room_new high.
module utl2_rx_occupancy #(
    parameter int CELLS = 4,
    localparam int UW   = $clog2(CELLS + 1),
    localparam int PW   = UW + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic release_cell,
    input  logic busy,
    output logic room_new,
    output logic room_clav
);
    logic [UW-1:0] used_q;
    logic [PW-1:0] pend;

    // Count including a commit that is landing this cycle
    always_comb begin
        pend      = PW'(used_q) + PW'(commit);
        room_new  = pend < PW'(CELLS);
        room_clav = (pend + PW'(busy)) < PW'(CELLS);
    end

    // Update committed-cell count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
        end else if (release_cell && pend != '0) begin
            used_q <= UW'(pend - PW'(1));
        end else begin
            used_q <= UW'(pend);
        end
    end

    // R10: never more cells committed than the buffer holds
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= UW'(CELLS));

endmodule

// File: rtl/utl2_rx_capture.sv
`timescale 1ns/1ps
// Module: cell capture engine. Takes words from the transmit bus, checks
// odd parity and cell length, writes words into the current cell slot and
// decides keep / discard. A discarded cell leaves the slot pointer alone,
// so its words are overwritten by the next cell.
// Assumes room_new reflects committed cells only (the open cell excluded).
module utl2_rx_capture #(
    parameter int BUS_W = 8,
    parameter int CELLS = 4,
    parameter int CW    = 53,
    parameter int AW    = 8,
    localparam int SW    = $clog2(CELLS),
    localparam int CNT_W = $clog2(CW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_en,
    input  logic             par_drop,
    input  logic             enb_n,
    input  logic             soc,
    input  logic [BUS_W-1:0] data,
    input  logic             prty,
    input  logic             room_new,
    output logic             busy,
    output logic             commit,
    output logic             buf_we,
    output logic [AW-1:0]    buf_waddr,
    output logic [BUS_W-1:0] buf_wdata,
    output logic             stat_bad_len,
    output logic             stat_par_err,
    output logic             stat_drop
);
    import utl2_rx_pkg::*;

    rx_state_t        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SW-1:0]    slot_q;
    logic             acc_q;
    logic             word_v;
    logic             perr_w;
    logic [AW-1:0]    base;
    logic [SW-1:0]    slot_nx;

    // Word qualification, parity test and slot addressing
    always_comb begin
        word_v  = !enb_n;
        perr_w  = par_en && !(^{data, prty});
        base    = AW'(slot_q) * AW'(CW);
        slot_nx = (slot_q == SW'(CELLS - 1)) ? '0 : slot_q + SW'(1);
        busy    = (state_q == ST_BODY);
    end

    // Capture state machine, buffer writes and outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            slot_q       <= '0;
            acc_q        <= 1'b0;
            commit       <= 1'b0;
            buf_we       <= 1'b0;
            buf_waddr    <= '0;
            buf_wdata    <= '0;
            stat_bad_len <= 1'b0;
            stat_par_err <= 1'b0;
            stat_drop    <= 1'b0;
        end else begin
            commit       <= 1'b0;
            buf_we       <= 1'b0;
            stat_bad_len <= 1'b0;
            stat_par_err <= 1'b0;
            stat_drop    <= 1'b0;
            if (word_v) begin
                stat_par_err <= perr_w;
                if (soc) begin
                    if (state_q == ST_BODY) begin
                        stat_bad_len <= 1'b1;
                        stat_drop    <= 1'b1;
                    end
                    if (room_new) begin
                        state_q   <= ST_BODY;
                        cnt_q     <= CNT_W'(1);
                        acc_q     <= perr_w;
                        buf_we    <= 1'b1;
                        buf_waddr <= base;
                        buf_wdata <= data;
                    end else begin
                        state_q   <= ST_SKIP;
                        stat_drop <= 1'b1;
                    end
                end else begin
                    unique case (state_q)
                        ST_BODY: begin
                            buf_we    <= 1'b1;
                            buf_waddr <= base + AW'(cnt_q);
                            buf_wdata <= data;
                            cnt_q     <= cnt_q + CNT_W'(1);
                            acc_q     <= acc_q | perr_w;
                            if (cnt_q == CNT_W'(CW - 1)) begin
                                if ((acc_q | perr_w) && par_drop) begin
                                    stat_drop <= 1'b1;
                                    state_q   <= ST_IDLE;
                                end else begin
                                    commit  <= 1'b1;
                                    slot_q  <= slot_nx;
                                    state_q <= ST_FULL;
                                end
                            end
                        end
                        ST_FULL: begin
                            stat_bad_len <= 1'b1;
                            state_q      <= ST_LONG;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R7, R11: nothing is written while trimming a long cell or skipping one
    p_no_write_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP || state_q == ST_LONG) |-> !buf_we);

    // R5: every write lands inside the buffer
    p_waddr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (buf_waddr < AW'(CELLS * CW)));

    // R9: a cell is either committed or discarded, never both at once
    p_ok_drop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({commit, stat_drop}) <= 1);

endmodule

// File: rtl/utl2_cell_rx.sv
`timescale 1ns/1ps
// Module: UTOPIA Level 2 slave cell receiver, top level. Joins the poll
// responder, the capture engine and the occupancy counter. Drives the write
// port of an external four-cell buffer and emits one-cycle outcome pulses.
// Assumes BUS_W is 8 or 16 and CELLS is at least 2.
module utl2_cell_rx #(
    parameter int BUS_W = 8,
    parameter int CELLS = 4,
    localparam int CW   = utl2_rx_pkg::cell_words(BUS_W),
    localparam int AW   = $clog2(CELLS * CW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mphy,
    input  logic [4:0]       cfg_addr,
    input  logic             cfg_par_en,
    input  logic             cfg_par_drop,
    input  logic [4:0]       tx_addr,
    input  logic             tx_enb_n,
    input  logic             tx_soc,
    input  logic [BUS_W-1:0] tx_data,
    input  logic             tx_prty,
    output logic             clav_o,
    output logic             clav_oe,
    output logic             buf_we,
    output logic [AW-1:0]    buf_waddr,
    output logic [BUS_W-1:0] buf_wdata,
    input  logic             cell_release,
    output logic             stat_cell_ok,
    output logic             stat_bad_len,
    output logic             stat_par_err,
    output logic             stat_drop
);
    logic busy;
    logic commit;
    logic room_new;
    logic room_clav;

    utl2_rx_poll u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mphy  (cfg_mphy),
        .cfg_addr  (cfg_addr),
        .poll_addr (tx_addr),
        .room      (room_clav),
        .clav_o    (clav_o),
        .clav_oe   (clav_oe)
    );

    utl2_rx_capture #(
        .BUS_W (BUS_W),
        .CELLS (CELLS),
        .CW    (CW),
        .AW    (AW)
    ) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .par_en       (cfg_par_en),
        .par_drop     (cfg_par_drop),
        .enb_n        (tx_enb_n),
        .soc          (tx_soc),
        .data         (tx_data),
        .prty         (tx_prty),
        .room_new     (room_new),
        .busy         (busy),
        .commit       (commit),
        .buf_we       (buf_we),
        .buf_waddr    (buf_waddr),
        .buf_wdata    (buf_wdata),
        .stat_bad_len (stat_bad_len),
        .stat_par_err (stat_par_err),
        .stat_drop    (stat_drop)
    );

    utl2_rx_occupancy #(
        .CELLS (CELLS)
    ) u_occ (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (commit),
        .release_cell (cell_release),
        .busy         (busy),
        .room_new     (room_new),
        .room_clav    (room_clav)
    );

    // Committed-cell pulse is the capture engine's commit strobe
    always_comb begin
        stat_cell_ok = commit;
    end

    // R12: outputs quiet right after a reset cycle
    p_reset_quiet_r12: assert property (@(posedge clk)
        $past(!rst_n) |-> !(clav_o || clav_oe || buf_we || stat_drop));

endmodule

// File: tb/test_utl2_cell_rx.sv
`timescale 1ns/1ps
module test_utl2_cell_rx;
    localparam int W  = 8;
    localparam int CW = 53;
    localparam int NV = 8;

    // len, bad word (-1 none), par_en, par_drop, ok, bad_len, drop, perr, writes
    // a len shorter than CW is followed by one clean full cell
    localparam int VEC [NV][9] = '{
        '{53, -1, 1, 0, 1, 0, 0, 0, 53},
        '{60, -1, 1, 0, 1, 1, 0, 0, 53},
        '{10, -1, 1, 0, 1, 1, 1, 0, 63},
        '{53,  5, 1, 0, 1, 0, 0, 1, 53},
        '{53, 52, 1, 1, 0, 0, 1, 1, 53},
        '{53,  0, 0, 0, 1, 0, 0, 0, 53},
        '{ 1, -1, 1, 0, 1, 1, 1, 0, 54},
        '{53, 20, 0, 1, 1, 0, 0, 0, 53}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_mphy = 1'b0;
    logic [4:0]   cfg_addr = 5'd5;
    logic         cfg_par_en = 1'b1;
    logic         cfg_par_drop = 1'b0;
    logic [4:0]   tx_addr = 5'd0;
    logic         tx_enb_n = 1'b1;
    logic         tx_soc = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_prty = 1'b0;
    logic         clav_o, clav_oe, buf_we;
    logic [7:0]   buf_waddr;
    logic [W-1:0] buf_wdata;
    logic         cell_release = 1'b0;
    logic         stat_cell_ok, stat_bad_len, stat_par_err, stat_drop;

    int n_tests = 0;
    int n_fail  = 0;
    int m_we = 0, m_ok = 0, m_bad = 0, m_drop = 0, m_perr = 0;
    int last_addr = 0, last_data = 0;

    utl2_cell_rx #(.BUS_W(W), .CELLS(4)) i_utl2_cell_rx (
        .clk(clk), .rst_n(rst_n), .cfg_mphy(cfg_mphy), .cfg_addr(cfg_addr),
        .cfg_par_en(cfg_par_en), .cfg_par_drop(cfg_par_drop),
        .tx_addr(tx_addr), .tx_enb_n(tx_enb_n), .tx_soc(tx_soc),
        .tx_data(tx_data), .tx_prty(tx_prty), .clav_o(clav_o),
        .clav_oe(clav_oe), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .cell_release(cell_release),
        .stat_cell_ok(stat_cell_ok), .stat_bad_len(stat_bad_len),
        .stat_par_err(stat_par_err), .stat_drop(stat_drop)
    );

    always #5 clk = ~clk;

    // Output monitor, sampled between edges
    always @(negedge clk) begin
        if (buf_we) begin
            m_we++;
            last_addr = int'(buf_waddr);
            last_data = int'(buf_wdata);
        end
        m_ok   += int'(stat_cell_ok);
        m_bad  += int'(stat_bad_len);
        m_drop += int'(stat_drop);
        m_perr += int'(stat_par_err);
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send_cell(input int len, input int bad, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            tx_enb_n = 1'b0;
            tx_soc   = (i == 0);
            tx_data  = W'(i * 3 + seed);
            tx_prty  = (~^tx_data) ^ (i == bad);
        end
        @(negedge clk);
        tx_enb_n = 1'b1;
        tx_soc   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic release_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cell_release = 1'b1;
            @(negedge clk); cell_release = 1'b0;
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int b_we, b_ok, b_bad, b_drop, b_perr;
        int slot;
        slot = 0;

        // R12: reset state
        idle(3);
        #2;
        chk("R12 clav_oe in reset", int'(clav_oe), 0);
        chk("R12 clav_o in reset", int'(clav_o), 0);
        chk("R12 buf_we in reset", int'(buf_we), 0);
        chk("R12 pulses in reset", m_ok + m_drop + m_bad + m_perr, 0);
        rst_n = 1'b1;

        // R4: single-PHY drives and reports room
        idle(2); #2;
        chk("R4 sphy oe", int'(clav_oe), 1);
        chk("R4 sphy clav empty", int'(clav_o), 1);

        // R1: word without start-of-cell while idle is not written
        @(negedge clk); tx_enb_n = 1'b0; tx_data = 8'h55; tx_prty = ~^8'h55;
        @(negedge clk); tx_enb_n = 1'b1;
        idle(2); #2;
        chk("R1 stray word not written", m_we, 0);

        // R2/R3: multi-PHY polling
        @(negedge clk); cfg_mphy = 1'b1; tx_addr = 5'd5;
        @(negedge clk); #2;
        chk("R2 polled own addr oe", int'(clav_oe), 1);
        chk("R2 polled own addr clav", int'(clav_o), 1);
        @(negedge clk); tx_addr = 5'd6;
        @(negedge clk); #2;
        chk("R2 other addr oe", int'(clav_oe), 0);
        chk("R2 other addr clav", int'(clav_o), 0);
        @(negedge clk); cfg_addr = 5'd31; tx_addr = 5'd31;
        @(negedge clk); #2;
        chk("R3 null addr silent", int'(clav_oe), 0);
        @(negedge clk); cfg_mphy = 1'b0; cfg_addr = 5'd5;
        idle(1);

        // Table of cell shapes: R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            @(negedge clk); #2;
            b_we = m_we; b_ok = m_ok; b_bad = m_bad; b_drop = m_drop; b_perr = m_perr;
            cfg_par_en   = VEC[v][2] != 0;
            cfg_par_drop = VEC[v][3] != 0;
            send_cell(VEC[v][0], VEC[v][1], v * 16);
            if (VEC[v][0] < CW) send_cell(CW, -1, v * 16);
            idle(3); #2;
            chk($sformatf("R5 v%0d cell ok", v), m_ok - b_ok, VEC[v][4]);
            chk($sformatf("R7 R6 v%0d bad len", v), m_bad - b_bad, VEC[v][5]);
            chk($sformatf("R9 R6 v%0d drop", v), m_drop - b_drop, VEC[v][6]);
            chk($sformatf("R8 v%0d parity pulses", v), m_perr - b_perr, VEC[v][7]);
            chk($sformatf("R7 v%0d writes", v), m_we - b_we, VEC[v][8]);
            chk($sformatf("R5 R6 v%0d last addr", v), last_addr, slot * CW + CW - 1);
            chk($sformatf("R5 v%0d last data", v), last_data, ((CW - 1) * 3 + v * 16) & 8'hFF);
            slot = (slot + VEC[v][4]) % 4;
            release_n(VEC[v][4]);
        end
        cfg_par_en = 1'b1; cfg_par_drop = 1'b0;

        // R10: fill the buffer; fourth cell in progress already hides room
        for (int c = 0; c < 3; c++) send_cell(CW, -1, c);
        idle(2);
        @(negedge clk); tx_enb_n = 1'b0; tx_soc = 1'b1; tx_data = 8'h01; tx_prty = ~^8'h01;
        @(negedge clk); tx_soc = 1'b0;
        for (int i = 1; i < 4; i++) begin
            tx_data = W'(i); tx_prty = ~^tx_data;
            @(negedge clk);
        end
        tx_enb_n = 1'b1;
        idle(1); #2;
        chk("R10 clav low while last slot filling", int'(clav_o), 0);
        for (int i = 4; i < CW; i++) begin
            @(negedge clk); tx_enb_n = 1'b0; tx_data = W'(i); tx_prty = ~^tx_data;
        end
        @(negedge clk); tx_enb_n = 1'b1;
        idle(2); #2;
        chk("R10 clav low when full", int'(clav_o), 0);
        @(negedge clk); cfg_mphy = 1'b1; tx_addr = 5'd5;
        @(negedge clk); #2;
        chk("R10 mphy full oe", int'(clav_oe), 1);
        chk("R10 mphy full clav", int'(clav_o), 0);
        @(negedge clk); cfg_mphy = 1'b0;

        // R11: cell offered to a full buffer is skipped
        @(negedge clk); #2;
        b_we = m_we; b_ok = m_ok; b_drop = m_drop;
        send_cell(CW, -1, 9);
        idle(3); #2;
        chk("R11 skipped no writes", m_we - b_we, 0);
        chk("R11 skipped no ok", m_ok - b_ok, 0);
        chk("R11 skipped drop", m_drop - b_drop, 1);

        // R10: release frees room
        release_n(1);
        idle(2); #2;
        chk("R10 clav after release", int'(clav_o), 1);
        release_n(3);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule